// File: doc/BRIEF.md
# Buffered-Reload PWM Timer

This block is a 16-bit up-counter that generates a pulse-width-modulated output. Two compare registers set the waveform: the period register fixes the cycle length and the duty register fixes how long the output stays active. A prescaler divides the input clock by a power of two, and the counter advances by one on each prescaler tick. At every period match the counter returns to zero and the block raises a one-cycle period pulse.

Software writes the compare registers through a small write port, and the written values do not reach the compare logic at once. Each register has a shadow buffer, and the compare logic reads only the buffers. A write to the duty register arms a reload. At the next counter clear, both buffers then copy their registers in a single step. A write to the period register alone does not arm the reload. To change only the period, software writes the period and then writes the duty again with its current value.

Starting the timer loads both buffers directly from the registers and restarts the count from zero. Stopping the timer freezes the count and drives the output to its inactive level.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset, `pwm_out` and `period_pulse` are 0 and the timer is stopped.
- R2: While running with buffered period P and prescale select k, `period_pulse` is high for one clock every (P+1)·2^k clocks, in the cycle in which the counter has just cleared to 0.
- R3: While running, the active PWM level holds while the count is below the buffered duty D, and the inactive level holds from count D up to the clear. A duty of 0 gives a waveform that is never active. A duty above the period gives a waveform that is always active.
- R4: A write to the period register (address 1) with no duty write after it leaves the period in use unchanged over any number of clears.
- R5: A write to the duty register (address 2) arms a reload. At the next counter clear, both buffers take the current register values, and the reload is then disarmed.
- R6: When both registers are written before a clear, the new period and the new duty take effect at the same clear.
- R7: The prescale select k is held in control bits [3:1] and divides the counting rate by 2^k, for k from 0 to 7.
- R8: Clearing run (control bit 0) stops counting. While the timer is stopped, no period pulse appears and the output sits at its inactive level.
- R9: The write that sets run, with the prescale select allowed in that same write, loads both buffers directly from the registers, restarts the count from 0, and clears any armed reload.
- R10: Control bit 4 enables the output. When it is 0, `pwm_out` is 0. Control bit 5 inverts the output: the active level is 1 when this bit is 0 and 0 when it is 1. The control register sits at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 duty |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output pin |
| period_pulse | output | 1 | One-cycle pulse at each period clear |

## Verification
A stale or wrongly armed buffer shows at the ports within one period. The spacing of `period_pulse` reveals the period in use, and the active width of `pwm_out` reveals the duty in use, so a reload that fires too early, too late or not at all changes one of these measurements at the next clear. A prescaler or counter fault stretches or shrinks the pulse spacing in the first period after the start. A fault in the start or stop handling shows on the output as a pulse or an active level while the timer is stopped, or as a first period of the wrong length.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int PSEL_W = 3;
  localparam int PRE_W  = (1 << PSEL_W) - 1;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_DUTY   = 2'd2
  } reg_addr_e;

  // control field positions
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_PSL  = 1;
  localparam int CTRL_OE   = CTRL_PSL + PSEL_W;
  localparam int CTRL_POL  = CTRL_OE + 1;

  // mask of the low k prescaler bits: all ones means a tick
  function automatic logic [PRE_W-1:0] tick_mask(input logic [PSEL_W-1:0] k);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(k)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic duty_active(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] duty);
    return cnt < duty;
  endfunction
endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             reload_done,
  output logic             run,
  output logic             start,
  output logic             running,
  output logic [PSEL_W-1:0] psel,
  output logic             oe,
  output logic             pol,
  output logic [CNT_W-1:0] cmp_period,
  output logic [CNT_W-1:0] cmp_duty,
  output logic             arm
);
  logic run_d;
  logic wr_ctrl, wr_period, wr_duty;

  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_period = wr_en && (wr_addr == ADDR_PERIOD);
  assign wr_duty   = wr_en && (wr_addr == ADDR_DUTY);

  assign start   = run && !run_d;
  assign running = run && run_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      run_d      <= 1'b0;
      psel       <= '0;
      oe         <= 1'b0;
      pol        <= 1'b0;
      cmp_period <= '0;
      cmp_duty   <= '0;
    end else begin
      run_d <= run;
      if (wr_ctrl) begin
        run  <= wr_data[CTRL_RUN];
        psel <= wr_data[CTRL_PSL +: PSEL_W];
        oe   <= wr_data[CTRL_OE];
        pol  <= wr_data[CTRL_POL];
      end
      if (wr_period) cmp_period <= wr_data;
      if (wr_duty)   cmp_duty   <= wr_data;
    end
  end

  // reload arm: start clears, duty write sets, reload consumes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           arm <= 1'b0;
    else if (start)       arm <= 1'b0;
    else if (wr_duty)     arm <= 1'b1;
    else if (reload_done) arm <= 1'b0;
  end
endmodule

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale
  import pwm_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;

  assign mask = tick_mask(psel);
  assign tick = running && ((pcnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (!running) pcnt <= '0;
    else               pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core
  import pwm_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             running,
  input  logic             tick,
  input  logic             arm,
  input  logic [CNT_W-1:0] cmp_period,
  input  logic [CNT_W-1:0] cmp_duty,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] buf_period,
  output logic [CNT_W-1:0] buf_duty,
  output logic             match,
  output logic             reload_done,
  output logic             pulse,
  output logic             active
);
  assign match       = tick && (cnt == buf_period);
  assign reload_done = match && arm;
  assign active      = running && duty_active(cnt, buf_duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      buf_period <= '0;
      buf_duty   <= '0;
      pulse      <= 1'b0;
    end else if (start) begin
      cnt        <= '0;
      buf_period <= cmp_period;
      buf_duty   <= cmp_duty;
      pulse      <= 1'b0;
    end else begin
      pulse <= match;
      if (match) begin
        cnt <= '0;
        if (arm) begin
          buf_period <= cmp_period;
          buf_duty   <= cmp_duty;
        end
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [15:0]      wr_data,
  output logic             pwm_out,
  output logic             period_pulse
);
  logic              run, start, running, oe, pol, arm, tick;
  logic [PSEL_W-1:0] psel;
  logic [CNT_W-1:0]  cmp_period, cmp_duty, cnt, buf_period, buf_duty;
  logic              match, reload_done, active;

  pwm_tmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload_done(reload_done), .run(run),
    .start(start), .running(running), .psel(psel), .oe(oe), .pol(pol),
    .cmp_period(cmp_period), .cmp_duty(cmp_duty), .arm(arm)
  );

  pwm_tmr_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .running(running), .psel(psel), .tick(tick)
  );

  pwm_tmr_core u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .running(running),
    .tick(tick), .arm(arm), .cmp_period(cmp_period), .cmp_duty(cmp_duty),
    .cnt(cnt), .buf_period(buf_period), .buf_duty(buf_duty),
    .match(match), .reload_done(reload_done), .pulse(period_pulse),
    .active(active)
  );

  assign pwm_out = oe && (active ^ pol);
endmodule

// File: rtl/pwm_reload_timer_chk.sv
module pwm_reload_timer_chk
  import pwm_tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             running,
  input logic             start,
  input logic             tick,
  input logic             arm,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] buf_period,
  input logic             reload_done,
  input logic             period_pulse,
  input logic             pwm_out,
  input logic             oe,
  input logic             pol
);
  a_r2_pulse_at_clear: assert property (@(posedge clk) disable iff (!rst_n)
    period_pulse |-> (cnt == '0));

  a_r8_no_pulse_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> !period_pulse);

  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && oe) |-> (pwm_out == pol));

  a_r4_buffer_change_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_period != $past(buf_period)) |-> $past(start || reload_done));

  a_r9_start_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> !arm);

  a_r7_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(start)) |-> $stable(cnt));

  a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !pwm_out);
endmodule

bind pwm_reload_timer pwm_reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .running(running), .start(start),
  .tick(tick), .arm(arm), .cnt(cnt), .buf_period(buf_period),
  .reload_done(reload_done), .period_pulse(period_pulse),
  .pwm_out(pwm_out), .oe(oe), .pol(pol)
);

// File: tb/sim_pwm_reload_timer.sv
module sim_pwm_reload_timer;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  wire pwm_out, period_pulse;

  int checks = 0, failures = 0, cyc = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  pwm_reload_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
    .period_pulse(period_pulse));

  // behavioural reference
  int m_run = 0, m_prev = 0, m_k = 0, m_oe = 0, m_pol = 0;
  int m_p = 0, m_d = 0, m_bp = 0, m_bd = 0, m_cnt = 0, m_pc = 0;
  int m_arm = 0, m_pulse = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      int div, go, begin_now, hit;
      div = 1 << m_k;
      begin_now = (m_run != 0) && (m_prev == 0);
      go = (m_run != 0) && (m_prev != 0);
      hit = go && (m_pc % div == div - 1) && (m_cnt == m_bp);
      if (begin_now) begin
        m_cnt = 0; m_bp = m_p; m_bd = m_d; m_pulse = 0; m_arm = 0;
      end else begin
        m_pulse = hit;
        if (hit) begin
          m_cnt = 0;
          if (m_arm != 0) begin m_bp = m_p; m_bd = m_d; end
        end else if (go && (m_pc % div == div - 1)) m_cnt = m_cnt + 1;
        if (wr_en && wr_addr == 2) m_arm = 1;
        else if (hit) m_arm = 0;
      end
      m_pc = go ? (m_pc + 1) % 128 : 0;
      m_prev = m_run;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            m_run = wr_data[0]; m_k = int'(wr_data[3:1]);
            m_oe = wr_data[4]; m_pol = wr_data[5];
          end
          2'd1: m_p = int'(wr_data);
          2'd2: m_d = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  // interval monitor
  int last_pulse = -1, last_iv = 0;

  always @(negedge clk) begin
    int exp_pwm;
    cyc++;
    if (rst_n) begin
      exp_pwm = (m_oe != 0) &&
        ((((m_run != 0) && (m_prev != 0) && (m_cnt < m_bd)) ? 1 : 0) ^ m_pol);
      checks++;
      if (pwm_out !== exp_pwm[0] || period_pulse !== m_pulse[0]) begin
        failures++;
        $display("FAIL %s cyc=%0d pwm=%b/%0d pulse=%b/%0d", phase, cyc,
                 pwm_out, exp_pwm, period_pulse, m_pulse);
      end
      if (period_pulse === 1'b1) begin
        if (last_pulse >= 0) last_iv = cyc - last_pulse;
        last_pulse = cyc;
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ctrl: bit0 run, [3:1] k, bit4 oe, bit5 pol
  function automatic int ctl(int run, int k, int oe, int pol);
    return run | (k << 1) | (oe << 4) | (pol << 5);
  endfunction

  initial begin
    idle(3);
    chk("R1 pwm", int'(pwm_out), 0);
    chk("R1 pulse", int'(period_pulse), 0);
    rst_n = 1;
    idle(3);
    chk("R1 idle pwm", int'(pwm_out), 0);

    phase = "R2";
    wr(1, 9); wr(2, 4); wr(0, ctl(1, 0, 1, 0));
    idle(60);
    chk("R2 interval P=9", last_iv, 10);

    phase = "R3";
    wr(2, 0); idle(40);
    wr(2, 20); idle(40);
    wr(2, 4); idle(40);

    phase = "R4";
    wr(1, 5); idle(50);
    chk("R4 period write alone", last_iv, 10);

    phase = "R5";
    wr(2, 4); idle(40);
    chk("R5 rewrite duty arms", last_iv, 6);
    wr(2, 2); idle(30);
    chk("R5 duty only keeps period", last_iv, 6);

    phase = "R6";
    wr(1, 7); wr(2, 3); idle(40);
    chk("R6 batch period", last_iv, 8);

    phase = "R10";
    wr(0, ctl(1, 0, 1, 1)); idle(30);
    wr(0, ctl(1, 0, 0, 0)); idle(20);
    chk("R10 oe off", int'(pwm_out), 0);

    phase = "R8";
    wr(0, ctl(0, 0, 1, 0));
    last_pulse = -1; last_iv = 0;
    idle(50);
    chk("R8 no pulses stopped", last_pulse, -1);
    chk("R8 idle inactive", int'(pwm_out), 0);

    phase = "R9";
    wr(1, 11);
    wr(0, ctl(1, 2, 1, 0));
    idle(160);
    chk("R9 start loads period, R7 k=2", last_iv, 48);

    phase = "R7";
    wr(0, ctl(0, 0, 1, 0));
    wr(1, 2); wr(2, 1);
    wr(0, ctl(1, 7, 1, 0));
    last_pulse = -1; last_iv = 0;
    idle(1200);
    chk("R7 k=7 interval", last_iv, 384);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule